// File: doc/BRIEF.md
# Signed Subtract-and-Compare Unit

This block orders two small two's-complement operands. It does not compare the operands bit by bit. It forms their difference in a ripple adder: each bit of the second operand is inverted and the least significant carry-in is forced to one. The block then reads the ordering from the sign of that difference. When the subtraction has overflowed, the sign is corrected, because in that case a negative-looking result means the first operand is the larger one.

The outputs are three flags: greater, equal and less. Exactly one of them is high for every input pair. The raw difference and the overflow flag are also brought out, so that the arithmetic can be observed directly. The unit holds no state. Every output follows the present operands through combinational logic only, so it can sit anywhere in a pipeline stage that has room for a short carry chain.

Top module: `signedSubCompare`

## Requirements
- R1: `diffOut` equals `opA - opB` reduced modulo 2^4 (4-bit wraparound), produced as opA plus the inverse of opB plus one.
- R2: `ovfFlag` is high exactly when the two operands have different sign bits (bit 3) and bit 3 of `diffOut` differs from bit 3 of `opA`; that is, when the true signed difference lies outside −8..+7.
- R3: `isEqual` is high exactly when the 4-bit difference is zero, which is when `opA` equals `opB`.
- R4: `isLess` is high exactly when signed `opA` < signed `opB`. This must hold in both cases: when the subtraction overflows (for example −5 versus 4) and when it does not.
- R5: `isGreater` is high exactly when signed `opA` > signed `opB`. It stays low when the operands are equal, and must hold across overflow (for example 6 versus −3).
- R6: Exactly one of `isGreater`, `isEqual` and `isLess` is high for each of the 256 operand pairs.
- R7: The outputs depend only on the present operands. Applying a pair again after other pairs gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | First operand, two's complement |
| opB | input | 4 | Second operand, two's complement |
| isGreater | output | 1 | High when opA > opB (signed) |
| isEqual | output | 1 | High when opA == opB |
| isLess | output | 1 | High when opA < opB (signed) |
| diffOut | output | 4 | Wrapped difference opA − opB |
| ovfFlag | output | 1 | Signed overflow of the subtraction |

## Verification
Every result is due in the same cycle as the stimulus: no register lies between the operands and any output, so the latency is zero cycles. The driver applies each pair shortly after a rising clock edge and queues the expected flags, difference and overflow. The monitor pops and compares these at the following falling edge, half a period later, when the carry chain has settled. This is done for the eight named corner pairs, for all 256 pairs, and for a repeated pair that tests that no state is held.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  parameter int CmpWidth = 4;
  localparam int MsbIdx = CmpWidth - 1;

  typedef logic [CmpWidth-1:0] operand_t;

  // Strobes from the datapath to the ordering control
  typedef struct packed {
    operand_t diff;
    logic     carryIntoMsb;
    logic     carryOut;
    logic     signA;
    logic     signB;
  } subResult_t;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
    logic ovf;
  } orderFlags_t;
endpackage

// File: rtl/fullAdderCell.sv
module fullAdderCell (
  input  logic inA,
  input  logic inB,
  input  logic carryIn,
  output logic sum,
  output logic carryOut
);
  always_comb begin
    sum      = inA ^ inB ^ carryIn;
    carryOut = (inA & inB) | (carryIn & (inA ^ inB));
  end
endmodule

// File: rtl/subDatapath.sv
module subDatapath
  import cmp_pkg::*;
(
  input  operand_t   opA,
  input  operand_t   opB,
  output subResult_t result
);
  operand_t              bInv;
  operand_t              sumBits;
  logic [CmpWidth:0]     carryChain;

  assign bInv          = ~opB;
  assign carryChain[0] = 1'b1;  // subtract: +1 completes the two's complement

  for (genvar i = 0; i < CmpWidth; i++) begin : g_ripple
    fullAdderCell u_cell (
      .inA      (opA[i]),
      .inB      (bInv[i]),
      .carryIn  (carryChain[i]),
      .sum      (sumBits[i]),
      .carryOut (carryChain[i+1])
    );
  end

  always_comb begin
    result.diff         = sumBits;
    result.carryIntoMsb = carryChain[MsbIdx];
    result.carryOut     = carryChain[CmpWidth];
    result.signA        = opA[MsbIdx];
    result.signB        = opB[MsbIdx];
  end
endmodule

// File: rtl/orderControl.sv
module orderControl
  import cmp_pkg::*;
(
  input  subResult_t  result,
  output orderFlags_t flags
);
  logic diffMsb;
  logic signsDiffer;

  always_comb begin
    diffMsb     = result.diff[MsbIdx];
    signsDiffer = result.signA ^ result.signB;
    flags.ovf   = signsDiffer & (diffMsb ^ result.signA);
    flags.eq    = ~|result.diff;
    flags.lt    = diffMsb ^ flags.ovf;
    flags.gt    = ~(flags.lt | flags.eq);
  end

  // Overflow from operand signs must agree with the carry-chain view
  always_comb begin
    p_ovf_carry_r2: assert (flags.ovf == (result.carryIntoMsb ^ result.carryOut))
      else $error("R2 overflow disagrees with carry chain");
    p_eq_not_lt_r6: assert (!(flags.eq && flags.lt))
      else $error("R6 equal and less both high");
  end
endmodule

// File: rtl/signedSubCompare.sv
module signedSubCompare
  import cmp_pkg::*;
(
  input  logic [3:0] opA,
  input  logic [3:0] opB,
  output logic       isGreater,
  output logic       isEqual,
  output logic       isLess,
  output logic [3:0] diffOut,
  output logic       ovfFlag
);
  subResult_t  subRes;
  orderFlags_t flags;

  subDatapath u_datapath (
    .opA    (opA),
    .opB    (opB),
    .result (subRes)
  );

  orderControl u_control (
    .result (subRes),
    .flags  (flags)
  );

  assign isGreater = flags.gt;
  assign isEqual   = flags.eq;
  assign isLess    = flags.lt;
  assign diffOut   = subRes.diff;
  assign ovfFlag   = flags.ovf;

  always_comb begin
    p_diff_wrap_r1: assert (diffOut == 4'(opA - opB))
      else $error("R1 difference wrong");
    p_equal_r3: assert (isEqual == (opA == opB))
      else $error("R3 equality wrong");
    p_less_r4: assert (isLess == ($signed(opA) < $signed(opB)))
      else $error("R4 less wrong");
    p_greater_r5: assert (isGreater == ($signed(opA) > $signed(opB)))
      else $error("R5 greater wrong");
    p_one_hot_r6: assert ($onehot({isGreater, isEqual, isLess}))
      else $error("R6 flags not one-hot");
  end
endmodule

// File: tb/test_signedSubCompare.sv
module test_signedSubCompare;
  logic       clk = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic       isGreater, isEqual, isLess, ovfFlag;
  logic [3:0] diffOut;

  int checks = 0;
  int failures = 0;
  bit driveDone = 0;
  bit finished = 0;

  typedef struct packed {
    logic [3:0] a;
    logic [3:0] b;
    logic [3:0] diff;
    logic       ovf, gt, eq, lt;
  } expItem_t;

  expItem_t scoreQ[$];

  always #10 clk = ~clk;  // 50 MHz

  signedSubCompare i_signedSubCompare (
    .opA(opA), .opB(opB), .isGreater(isGreater), .isEqual(isEqual),
    .isLess(isLess), .diffOut(diffOut), .ovfFlag(ovfFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req,
               $signed(opA), $signed(opB), act, exp);
    end
  endtask

  task automatic drivePair(input int a, input int b);
    expItem_t it;
    int d;
    @(posedge clk);
    #2;
    opA = 4'(a);
    opB = 4'(b);
    d = a - b;
    it.a = 4'(a);
    it.b = 4'(b);
    it.diff = 4'(d);
    it.ovf = (d > 7) || (d < -8);
    it.gt = a > b;
    it.eq = a == b;
    it.lt = a < b;
    scoreQ.push_back(it);
  endtask

  // Monitor: results are combinational, due half a period after drive
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      expItem_t e;
      e = scoreQ.pop_front();
      check(diffOut == e.diff, "R1", diffOut, e.diff);
      check(ovfFlag == e.ovf, "R2", ovfFlag, e.ovf);
      check(isEqual == e.eq, "R3", isEqual, e.eq);
      check(isLess == e.lt, "R4", isLess, e.lt);
      check(isGreater == e.gt, "R5", isGreater, e.gt);
      check((32'(isGreater) + 32'(isEqual) + 32'(isLess)) == 1, "R6",
            int'(isGreater) + int'(isEqual) + int'(isLess), 1);
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    logic [6:0] firstSnap;
    // Bench reset phase: operands held at zero (A = B = 0 case)
    repeat (3) @(posedge clk);
    drivePair(0, 0);
    drivePair(6, 3);     // R5 greater
    drivePair(6, -3);    // R5 greater with overflow, R2
    drivePair(6, 7);     // R4 less
    drivePair(-5, -5);   // R3 equal
    drivePair(-5, -2);   // R4 less
    drivePair(-5, 4);    // R4 less with overflow, R2
    drivePair(-5, -7);   // R5 greater
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        drivePair(a, b);
    // R7: same pair after other traffic gives the same outputs
    drivePair(-5, 4);
    @(negedge clk);
    firstSnap = {isGreater, isEqual, isLess, diffOut};
    drivePair(3, 3);
    drivePair(-8, 7);
    drivePair(-5, 4);
    @(negedge clk);
    check({isGreater, isEqual, isLess, diffOut} == firstSnap, "R7",
          {isGreater, isEqual, isLess, diffOut}, firstSnap);
    @(negedge clk);
    driveDone = 1;
    finishRun();
  end

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!driveDone) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end
endmodule